// File: doc/BRIEF.md
# Dual-Mode FIFO Status Controller

This block is the pointer and status core of a two-clock FIFO that holds 256 words of 36 bits. A producer writes on one clock and a consumer reads on another. Each side sees a readiness flag and an active-low "almost" flag. Pointers cross between the clock domains as Gray code through two-flop synchronizers.

One of two read timing modes is chosen after a full reset. In standard mode, `rd_ok` means "not empty", and every word, the first included, is fetched by a read request. In fall-through mode, `rd_ok` means "output valid". The oldest word sits on `rd_data` without any request, and a read consumes it.

Two reset inputs are provided and may change at any time relative to the clocks:
- The full reset clears everything and re-arms mode selection.
- The partial reset empties the FIFO but keeps the chosen mode.

Top module: `fifo_status_ctl`

## Requirements
- R1: Words leave `rd_data` in the order they were accepted, with their value unchanged.
- R2: In standard mode (mode code 0), `rd_data` is loaded only at a `rd_clk` rising edge where `rd_en` and `rd_ok` are both HIGH. Otherwise it holds its value. `rd_ok` HIGH means at least one unread word is stored.
- R3: `mode_pin` is sampled once, at the `rd_clk` edge where the synchronized release of `rst_n` takes effect. HIGH selects standard mode and LOW selects fall-through mode (mode code 1). Later changes of `mode_pin` have no effect.
- R4: In fall-through mode, the oldest stored word appears on `rd_data` with `rd_ok` HIGH and no read request. A read with `rd_ok` HIGH consumes it.
- R5: While `rst_n` or `prst_n` has been LOW for at least four edges of each clock, `wr_room`, `rd_ok` and `ae_n` are LOW and `af_n` is HIGH.
- R6: After both resets are HIGH, `wr_room` rises at the second `wr_clk` rising edge after the first edge that samples them HIGH.
- R7: When a read removes the last available word, `rd_ok` is LOW from the next `rd_clk` edge. In fall-through mode this is the output word with no further word stored.
- R8: A write with `wr_room` LOW is discarded. A read request with `rd_ok` LOW neither moves the read pointer nor consumes data.
- R9: A partial reset empties the FIFO and keeps the mode chosen by the last full reset.
- R10: Once the pointer crossing has settled, `ae_n` is LOW exactly when the memory holds at most `AE_LEVEL` (8) words. `af_n` is LOW exactly when it holds at least 256 − `AF_LEVEL` (248) words.
- R11: `wr_room` is LOW once the memory holds 256 words. In fall-through mode the output register holds one more word, so it goes LOW after the 257th word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write data |
| wr_room | output | 1 | HIGH when a write will be accepted (not full / input ready) |
| af_n | output | 1 | LOW when almost full |
| rd_clk | input | 1 | Read clock |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Read data |
| rd_ok | output | 1 | Not empty (standard) / output valid (fall-through) |
| ae_n | output | 1 | LOW when almost empty |
| rst_n | input | 1 | Full reset, active low, asynchronous to both clocks |
| prst_n | input | 1 | Partial reset, active low, asynchronous to both clocks |
| mode_pin | input | 1 | Timing mode select, sampled after full reset |

## Verification
The data path is driven in several ways:
- A one-by-one fill to capacity followed by a full drain. This walks every occupancy level, so the almost-flag thresholds and the full point can be told apart from an off-by-one.
- Bursts of several lengths in fall-through mode. These separate a correct output-stage refill from a lost or duplicated word at the boundary where the output register empties.
- Reads while empty and writes while full, each followed by traffic. These show whether a pointer moved when it should not have.
- Full and partial resets with `mode_pin` flipped afterwards. These distinguish a mode that is latched once from one that follows the pin or is cleared by a partial reset.

// File: rtl/fifo_status_pkg.sv
// Shared types for the dual-mode FIFO status controller.
package fifo_status_pkg;
    // Read timing mode latched after a full reset.
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/fifo_sync2.sv
// Two-flop synchronizer for a W-bit vector into the clk domain.
// Assumes multi-bit inputs change at most one bit at a time (Gray code).
// rst_n is synchronous; tie it HIGH when synchronizing a reset itself.
module fifo_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two-stage capture of the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/fifo_wr_ctl.sv
// Write-side pointer and flags.
// Assumes rgray_s is the read pointer in Gray code, already synchronized to clk.
module fifo_wr_ctl #(
    parameter int AW       = 8,
    parameter int AF_LEVEL = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_s,
    output logic          push,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic          wr_room,
    output logic          af_n
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] wbin_nx, wgray_nx, rbin_s, used_nx;
    logic          full_nx;

    // Convert the synchronized read pointer from Gray to binary.
    always_comb begin
        for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
    end

    // Next pointer, fullness and occupancy after an accepted write.
    always_comb begin
        push     = wr_en & wr_room;
        wbin_nx  = wbin + PW'(push);
        wgray_nx = (wbin_nx >> 1) ^ wbin_nx;
        full_nx  = (wgray_nx == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
        used_nx  = wbin_nx - rbin_s;
    end

    assign waddr = wbin[AW-1:0];

    // Pointer and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin    <= '0;
            wgray   <= '0;
            wr_room <= 1'b0;
            af_n    <= 1'b1;
        end else begin
            wbin    <= wbin_nx;
            wgray   <= wgray_nx;
            wr_room <= !full_nx;
            af_n    <= !(used_nx >= PW'(DEPTH - AF_LEVEL));
        end
    end
endmodule

// File: rtl/fifo_rd_ctl.sv
// Read-side pointer, flags and timing-mode latch.
// Assumes wgray_s is the write pointer in Gray code, synchronized to clk.
// full_rst_n releases on the same edge as rst_n after a full reset.
module fifo_rd_ctl
    import fifo_status_pkg::*;
#(
    parameter int AW       = 8,
    parameter int AE_LEVEL = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          full_rst_n,
    input  logic          mode_pin,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_s,
    output logic          load,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic          rd_ok,
    output logic          ae_n,
    output logic          fwft,
    output logic          locked
);
    localparam int PW = AW + 1;

    rd_mode_e      mode_q;
    logic [PW-1:0] rbin_nx, rgray_nx, wbin_s, used_nx;
    logic          mem_has, rd_ok_nx;

    assign fwft = (mode_q == MODE_FWFT);

    // Latch the timing mode once after a full reset; a partial reset keeps it.
    always_ff @(posedge clk) begin
        if (!full_rst_n) begin
            locked <= 1'b0;
            mode_q <= MODE_STD;
        end else if (!locked) begin
            locked <= 1'b1;
            mode_q <= mode_pin ? MODE_STD : MODE_FWFT;
        end
    end

    // Convert the synchronized write pointer from Gray to binary.
    always_comb begin
        for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
    end

    // Decide whether memory is read this cycle and the next valid state.
    always_comb begin
        mem_has = (rgray != wgray_s);
        if (fwft) begin
            load     = mem_has & (!rd_ok | rd_en);
            rd_ok_nx = load ? 1'b1 : (rd_en ? 1'b0 : rd_ok);
        end else begin
            load     = rd_en & rd_ok;
            rd_ok_nx = 1'b0;
        end
        rbin_nx  = rbin + PW'(load);
        rgray_nx = (rbin_nx >> 1) ^ rbin_nx;
        if (!fwft) rd_ok_nx = (rgray_nx != wgray_s);
        used_nx  = wbin_s - rbin_nx;
    end

    assign raddr = rbin[AW-1:0];

    // Pointer and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
            rd_ok <= 1'b0;
            ae_n  <= 1'b0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rgray_nx;
            rd_ok <= rd_ok_nx;
            ae_n  <= !(used_nx <= PW'(AE_LEVEL));
        end
    end
endmodule

// File: rtl/fifo_status_ctl.sv
// Top of the dual-mode FIFO status controller: reset synchronizers,
// pointer crossings, storage array and the two side controllers.
// Assumes reset pulses last at least four edges of each clock.
module fifo_status_ctl #(
    parameter int DW       = 36,
    parameter int AW       = 8,
    parameter int AE_LEVEL = 8,
    parameter int AF_LEVEL = 8
) (
    input  logic          wr_clk,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wr_room,
    output logic          af_n,
    input  logic          rd_clk,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_ok,
    output logic          ae_n,
    input  logic          rst_n,
    input  logic          prst_n,
    input  logic          mode_pin
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic          any_rst_n;
    logic          wrst_n, rrst_n, rfull_n;
    logic          push, load, fwft, locked;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wbin, wgray, rbin, rgray, wgray_s, rgray_s;
    logic [DW-1:0] mem [DEPTH];

    assign any_rst_n = rst_n & prst_n;

    fifo_sync2 #(.W(1)) u_wrst  (.clk(wr_clk), .rst_n(1'b1), .d(any_rst_n), .q(wrst_n));
    fifo_sync2 #(.W(1)) u_rrst  (.clk(rd_clk), .rst_n(1'b1), .d(any_rst_n), .q(rrst_n));
    fifo_sync2 #(.W(1)) u_rfull (.clk(rd_clk), .rst_n(1'b1), .d(rst_n),     .q(rfull_n));

    fifo_sync2 #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
    fifo_sync2 #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

    fifo_wr_ctl #(.AW(AW), .AF_LEVEL(AF_LEVEL)) u_wr (
        .clk(wr_clk), .rst_n(wrst_n), .wr_en(wr_en), .rgray_s(rgray_s),
        .push(push), .waddr(waddr), .wbin(wbin), .wgray(wgray),
        .wr_room(wr_room), .af_n(af_n)
    );

    fifo_rd_ctl #(.AW(AW), .AE_LEVEL(AE_LEVEL)) u_rd (
        .clk(rd_clk), .rst_n(rrst_n), .full_rst_n(rfull_n), .mode_pin(mode_pin),
        .rd_en(rd_en), .wgray_s(wgray_s), .load(load), .raddr(raddr),
        .rbin(rbin), .rgray(rgray), .rd_ok(rd_ok), .ae_n(ae_n),
        .fwft(fwft), .locked(locked)
    );

    // Storage array write port.
    always_ff @(posedge wr_clk) begin
        if (push) mem[waddr] <= wr_data;
    end

    // Registered read port feeding the data output.
    always_ff @(posedge rd_clk) begin
        if (!rrst_n)   rd_data <= '0;
        else if (load) rd_data <= mem[raddr];
    end
endmodule

// File: rtl/fifo_status_chk.sv
// Protocol checker for fifo_status_ctl, attached by bind.
module fifo_status_chk #(
    parameter int PW = 9
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          wrst_n,
    input logic          rrst_n,
    input logic          rfull_n,
    input logic          wr_en,
    input logic          wr_room,
    input logic          af_n,
    input logic          rd_en,
    input logic          rd_ok,
    input logic          ae_n,
    input logic          fwft,
    input logic          locked,
    input logic [PW-1:0] wbin,
    input logic [PW-1:0] rbin
);
    // R5: write-side flags at reset levels after a reset cycle.
    a_r5_wr_reset_flags: assert property (@(posedge wr_clk)
        !wrst_n |=> (!wr_room && af_n));

    // R5: read-side flags at reset levels after a reset cycle.
    a_r5_rd_reset_flags: assert property (@(posedge rd_clk)
        !rrst_n |=> (!rd_ok && !ae_n));

    // R8: rejected write leaves the write pointer in place.
    a_r8_no_overflow: assert property (@(posedge wr_clk) disable iff (!wrst_n)
        (wr_en && !wr_room) |=> $stable(wbin));

    // R8: standard-mode read while empty leaves the read pointer in place.
    a_r8_no_underflow: assert property (@(posedge rd_clk) disable iff (!rrst_n)
        (!fwft && rd_en && !rd_ok) |=> $stable(rbin));

    // R3: once latched, the mode does not change until a full reset.
    a_r3_mode_held: assert property (@(posedge rd_clk) disable iff (!rfull_n)
        locked |=> $stable(fwft));
endmodule

bind fifo_status_ctl fifo_status_chk #(.PW(AW + 1)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .wrst_n(wrst_n), .rrst_n(rrst_n),
    .rfull_n(rfull_n), .wr_en(wr_en), .wr_room(wr_room), .af_n(af_n),
    .rd_en(rd_en), .rd_ok(rd_ok), .ae_n(ae_n), .fwft(fwft), .locked(locked),
    .wbin(wbin), .rbin(rbin)
);

// File: tb/test_fifo_status_ctl.sv
module test_fifo_status_ctl;
    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic        wr_room, af_n, rd_ok, ae_n;
    logic [35:0] rd_data;
    logic        rst_n = 1'b0, prst_n = 1'b1, mode_pin = 1'b1;
    int          n_tests = 0, n_fail = 0;
    logic        fwft_exp = 1'b0;
    logic [35:0] got;

    fifo_status_ctl i_fifo_status_ctl (
        .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data), .wr_room(wr_room), .af_n(af_n),
        .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data), .rd_ok(rd_ok), .ae_n(ae_n),
        .rst_n(rst_n), .prst_n(prst_n), .mode_pin(mode_pin)
    );

    always #4 wr_clk = ~wr_clk;
    initial begin
        #2;
        forever #4 rd_clk = ~rd_clk;
    end

    function automatic logic [35:0] val(input int i);
        return {4'(i), 32'(i) * 32'h0101_0101 ^ 32'h5A5A_0000};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Apply a full or partial reset, check reset levels (R5) and release timing (R6).
    task automatic do_reset(input bit full, input logic pin);
        @(negedge wr_clk);
        mode_pin = pin;
        if (full) rst_n = 1'b0; else prst_n = 1'b0;
        repeat (6) @(negedge wr_clk);
        chk("R5 wr_room", wr_room, 0);
        chk("R5 rd_ok", rd_ok, 0);
        chk("R5 ae_n", ae_n, 0);
        chk("R5 af_n", af_n, 1);
        rst_n = 1'b1;
        prst_n = 1'b1;
        @(negedge wr_clk);
        @(negedge wr_clk);
        chk("R6 wr_room before", wr_room, 0);
        @(negedge wr_clk);
        chk("R6 wr_room rise", wr_room, 1);
        repeat (8) @(negedge wr_clk);
        mode_pin = !pin;   // R3: later pin changes must be ignored
    endtask

    task automatic push(input logic [35:0] d);
        @(negedge wr_clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge rd_clk);
    endtask

    task automatic pop(output logic [35:0] d);
        @(negedge rd_clk);
        if (fwft_exp) d = rd_data;
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        if (!fwft_exp) d = rd_data;
    endtask

    initial begin
        // ---- full reset into standard mode ----
        do_reset(1'b1, 1'b1);
        fwft_exp = 1'b0;

        push(val(0));
        settle();
        chk("R2 not empty", rd_ok, 1);
        chk("R3 no fall-through in standard", rd_data, 0);
        pop(got);
        chk("R1 data", got, val(0));
        chk("R7 std empty after last read", rd_ok, 0);

        // R8: reads while empty change nothing
        @(negedge rd_clk);
        rd_en = 1'b1;
        repeat (3) @(negedge rd_clk);
        rd_en = 1'b0;
        chk("R8 read while empty keeps data", rd_data, val(0));
        push(val(1));
        settle();
        pop(got);
        chk("R8 pointer unmoved by empty read", got, val(1));

        // Fill sweep: every occupancy level (R10, R11)
        for (int k = 1; k <= 256; k++) begin
            push(val(100 + k));
            settle();
            chk("R10 ae_n", ae_n, (k > 8));
            chk("R10 af_n", af_n, (k < 248));
            chk("R11 wr_room", wr_room, (k < 256));
        end
        push(36'hBAD_BAD_BAD);
        push(36'hDEA_DDE_ADD);
        for (int k = 1; k <= 256; k++) begin
            pop(got);
            chk("R1 drain order", got, val(100 + k));
            if (k == 256) chk("R8 overflow discarded / R7 empty", rd_ok, 0);
        end
        settle();
        chk("R11 room after drain", wr_room, 1);

        // ---- partial reset keeps standard mode (R9) ----
        push(val(7));
        push(val(8));
        do_reset(1'b0, 1'b0);
        settle();
        chk("R9 emptied", rd_ok, 0);
        push(val(9));
        settle();
        chk("R9 still standard, no fall-through", rd_data, 0);
        pop(got);
        chk("R9 data", got, val(9));

        // ---- full reset into fall-through mode ----
        do_reset(1'b1, 1'b0);
        fwft_exp = 1'b1;
        push(val(20));
        settle();
        chk("R4 output ready without read", rd_ok, 1);
        chk("R4 word presented", rd_data, val(20));
        pop(got);
        chk("R4 consumed", got, val(20));
        chk("R7 fwft drop", rd_ok, 0);

        // Bursts of several lengths
        for (int b = 1; b <= 6; b++) begin
            automatic int n = (b == 6) ? 17 : b;
            for (int i = 0; i < n; i++) push(val(1000 * b + i));
            settle();
            for (int i = 0; i < n; i++) begin
                pop(got);
                chk("R1 burst order", got, val(1000 * b + i));
            end
            chk("R7 fwft drop after burst", rd_ok, 0);
        end

        // R8 in fall-through: read requests while not ready
        @(negedge rd_clk);
        rd_en = 1'b1;
        repeat (3) @(negedge rd_clk);
        rd_en = 1'b0;
        push(val(55));
        settle();
        chk("R8 fwft next word intact", rd_data, val(55));
        pop(got);

        // Fill in fall-through: output stage holds one extra word (R11)
        for (int k = 0; k < 257; k++) push(val(300 + k));
        settle();
        chk("R11 fwft full after 257", wr_room, 0);
        push(36'hFFF_FFF_FFF);
        for (int k = 0; k < 257; k++) begin
            pop(got);
            chk("R1 fwft drain", got, val(300 + k));
        end
        chk("R8 fwft overflow discarded", rd_ok, 0);

        // ---- partial reset keeps fall-through mode (R9) ----
        push(val(60));
        do_reset(1'b0, 1'b1);
        settle();
        chk("R9 emptied fwft", rd_ok, 0);
        push(val(61));
        settle();
        chk("R9 fwft kept", rd_ok, 1);
        chk("R9 fwft word", rd_data, val(61));

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        #1_200_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule